// File: doc/BRIEF.md
# Self-Pacing DMA Event Sequencer for a Block Decoder

This block is the input and output control of a block-decoding coprocessor that a DMA engine feeds. It paces the DMA engine with two single-cycle event pulses. The write-request event asks for the next input phase. The read-request event asks for results to be drained. The block issues the first write request by itself, right after reset, with no command from the CPU. A DMA channel chain that is armed before reset is released therefore runs without further software action.

Input arrives on a 32-bit write port in three fixed phases: configuration words, then systematic and parity data, then interleaver indexes. The block detects the end of each phase only by counting accepted write beats. It compares that count with a length derived from the frame length, which is latched from the first configuration word. The frame length counts information symbols only, not tail symbols. The interleaver phase length is rounded up, so it holds more than one entry per symbol.

When the interleaver phase completes, a fixed-latency stub stands in for the decoder. The stub then presents its result words on the read port. After the last result word is read, the block asks for the next frame.

Top module: `dma_evt_seq`

## Requirements
- R1: On the first clock edge after reset is released, `wr_req_evt` goes high for one cycle. After reset, `phase` reads 0 (config) and `err` reads 0.
- R2: The config phase ends after exactly 16 accepted beats (64 bytes). The low FL_W bits of the first config beat become the frame length FL, which must be at least 1. The edge that accepts the 16th beat raises `wr_req_evt` and sets `phase` to 1 (data).
- R3: The data phase ends after exactly 2*ceil(FL/2) beats. The edge that accepts the final data beat raises `wr_req_evt` and sets `phase` to 2 (interleaver).
- R4: The interleaver phase ends after exactly 2*ceil((FL+3)/4) beats. Until then, `wait_ilv` stays 1, `phase` stays 2 and `rd_req_evt` stays 0.
- R5: The edge that accepts the final interleaver beat sets `phase` to 3 (busy) and clears `wait_ilv`. `rd_req_evt` then pulses exactly PROC_CYCLES edges later.
- R6: After `rd_req_evt`, the block offers ceil(FL/32) result words. Word i reads {i[15:0], FL zero-extended to 16 bits}, and each `rd_en` cycle advances to the next word. Outside the output window, `rd_data` is 0.
- R7: The edge that accepts the final result read raises `wr_req_evt` and returns `phase` to 0.
- R8: A write while `phase` is 3 changes no phase or count. It sets `err`, which stays set until reset.
- R9: `wr_req_evt` and `rd_req_evt` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| wr_en | input | 1 | Write beat valid |
| wr_data | input | 32 | Write beat data |
| rd_en | input | 1 | Read strobe, pops one result word |
| rd_data | output | 32 | Current result word, 0 when not in output |
| wr_req_evt | output | 1 | Write-request event pulse |
| rd_req_evt | output | 1 | Read-request event pulse |
| phase | output | 2 | 0 config, 1 data, 2 interleaver, 3 busy/output |
| wait_ilv | output | 1 | Waiting for interleaver indexes |
| err | output | 1 | Sticky write-while-busy error |

## Verification
The bench builds the block with FL_W = 12 and PROC_CYCLES = 5. The short latency keeps every frame brief. The 12-bit field lets frames of 1, 5, 40 and 70 symbols be tried, which yields one, two and three result words. Those lengths exercise both roundings. Frames of 1 and 5 show where the interleaver count exceeds the entry count, and the checks made one beat before each phase ends catch any length that is off by one rounding step.

// File: rtl/dseq_pkg.sv
// Shared phase encoding and fixed config length for the DMA event sequencer.
package dseq_pkg;
    typedef enum logic [1:0] {
        PH_CFG  = 2'd0,
        PH_DAT  = 2'd1,
        PH_ILV  = 2'd2,
        PH_BUSY = 2'd3
    } phase_e;

    localparam int CFG_BEATS = 16;
endpackage

// File: rtl/dseq_len_calc.sv
// Derives the per-phase beat counts and the result word count from the
// latched frame length. Purely combinational. Assumes FL_W >= 4.
module dseq_len_calc #(
    parameter int FL_W = 16,
    localparam int LW  = FL_W + 2
) (
    input  logic [FL_W-1:0] fl,
    output logic [LW-1:0]   dat_beats,
    output logic [LW-1:0]   ilv_beats,
    output logic [LW-1:0]   res_words
);
    logic [LW-1:0] flx;

    // Round the three lengths up to their required granularity.
    always_comb begin
        flx       = {2'b00, fl};
        dat_beats = ((flx + LW'(1)) >> 1) << 1;
        ilv_beats = ((flx + LW'(6)) >> 2) << 1;
        res_words = (flx + LW'(31)) >> 5;
    end
endmodule

// File: rtl/dseq_proc_stub.sv
// Fixed-latency stand-in for the decoder. It waits PROC_CYCLES edges after
// start, pulses the read request, and serves res_words result words.
// Assumes PROC_CYCLES >= 2 and res_words >= 1 whenever it is started.
module dseq_proc_stub #(
    parameter int FL_W        = 16,
    parameter int PROC_CYCLES = 24,
    localparam int LW = FL_W + 2,
    localparam int TW = $clog2(PROC_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FL_W-1:0] fl,
    input  logic [LW-1:0]   res_words,
    input  logic            rd_en,
    output logic [31:0]     rd_data,
    output logic            rd_req_evt,
    output logic            last_read
);
    logic          run_q, out_q, req_q;
    logic [TW-1:0] tmr_q;
    logic [LW-1:0] idx_q;

    // Final read is accepted when output is active and the last word is popped.
    always_comb begin
        last_read = out_q && rd_en && (idx_q == res_words - LW'(1));
        rd_data   = out_q ? {16'(idx_q), 16'(fl)} : 32'd0;
    end

    // Latency timer, output window and result index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
            req_q <= 1'b0;
            tmr_q <= '0;
            idx_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                tmr_q <= '0;
            end else if (run_q) begin
                if (tmr_q == TW'(PROC_CYCLES - 1)) begin
                    run_q <= 1'b0;
                    out_q <= 1'b1;
                    req_q <= 1'b1;
                    idx_q <= '0;
                end else begin
                    tmr_q <= tmr_q + TW'(1);
                end
            end
            if (out_q && rd_en) begin
                if (last_read) out_q <= 1'b0;
                else           idx_q <= idx_q + LW'(1);
            end
        end
    end

    assign rd_req_evt = req_q;

    // R6: the result index never leaves the window of valid words.
    assert_idx_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> (idx_q < res_words));
    // R9: the read request is a single-cycle pulse.
    assert_rd_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_evt |=> !rd_req_evt);
endmodule

// File: rtl/dma_evt_seq.sv
// Front-end sequencer of a DMA-fed block decoder. After reset it requests
// input by itself, then counts write beats through the config, data and
// interleaver phases, starts the processing stub, and requests the read-out.
// Assumes the programmed frame length is at least 1.
module dma_evt_seq #(
    parameter int FL_W        = 16,
    parameter int PROC_CYCLES = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        wr_req_evt,
    output logic        rd_req_evt,
    output logic [1:0]  phase,
    output logic        wait_ilv,
    output logic        err
);
    import dseq_pkg::*;

    localparam int LW = FL_W + 2;

    phase_e          phase_q;
    logic [LW-1:0]   cnt_q, tgt;
    logic [FL_W-1:0] fl_q;
    logic            boot_q, wr_req_q, err_q;
    logic            beat_ok, last_beat, last_read;
    logic [LW-1:0]   dat_beats, ilv_beats, res_words;

    dseq_len_calc #(.FL_W(FL_W)) u_len (
        .fl        (fl_q),
        .dat_beats (dat_beats),
        .ilv_beats (ilv_beats),
        .res_words (res_words)
    );

    // Select the beat target of the current phase and spot its final beat.
    always_comb begin
        case (phase_q)
            PH_CFG:  tgt = LW'(CFG_BEATS);
            PH_DAT:  tgt = dat_beats;
            PH_ILV:  tgt = ilv_beats;
            default: tgt = '0;
        endcase
        beat_ok   = wr_en && (phase_q != PH_BUSY);
        last_beat = beat_ok && ((cnt_q + LW'(1)) == tgt);
    end

    dseq_proc_stub #(.FL_W(FL_W), .PROC_CYCLES(PROC_CYCLES)) u_stub (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (last_beat && (phase_q == PH_ILV)),
        .fl         (fl_q),
        .res_words  (res_words),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_req_evt (rd_req_evt),
        .last_read  (last_read)
    );

    // Phase progression, beat counting, frame-length latch, events and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_CFG;
            cnt_q    <= '0;
            fl_q     <= '0;
            boot_q   <= 1'b1;
            wr_req_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            boot_q   <= 1'b0;
            wr_req_q <= boot_q || (last_beat && phase_q != PH_ILV) || last_read;
            if (wr_en && phase_q == PH_BUSY) err_q <= 1'b1;
            if (beat_ok && phase_q == PH_CFG && cnt_q == '0)
                fl_q <= wr_data[FL_W-1:0];
            if (beat_ok) begin
                if (last_beat) begin
                    cnt_q <= '0;
                    case (phase_q)
                        PH_CFG:  phase_q <= PH_DAT;
                        PH_DAT:  phase_q <= PH_ILV;
                        default: phase_q <= PH_BUSY;
                    endcase
                end else begin
                    cnt_q <= cnt_q + LW'(1);
                end
            end
            if (last_read) phase_q <= PH_CFG;
        end
    end

    assign wr_req_evt = wr_req_q;
    assign phase      = phase_q;
    assign wait_ilv   = (phase_q == PH_ILV);
    assign err        = err_q;

    // R2: the config beat count stays below its fixed length.
    assert_cfg_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CFG) |-> (cnt_q < LW'(CFG_BEATS)));
    // R4: no read request while interleaver indexes are still expected.
    assert_no_read_while_ilv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wait_ilv |-> !rd_req_evt);
    // R8: the error flag is sticky.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R8: a write while busy does not move the phase.
    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BUSY && wr_en && !last_read) |=> (phase_q == PH_BUSY));
    // R9: the write request is a single-cycle pulse.
    assert_wr_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_evt |=> !wr_req_evt);
endmodule

// File: tb/sim_dma_evt_seq.sv
// Directed bench for dma_evt_seq: one task per scenario, each checking itself.
module sim_dma_evt_seq;
    localparam int FL_W = 12;
    localparam int PROC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        wr_req_evt, rd_req_evt, wait_ilv, err;
    logic [1:0]  phase;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dma_evt_seq #(.FL_W(FL_W), .PROC_CYCLES(PROC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .wr_req_evt(wr_req_evt),
        .rd_req_evt(rd_req_evt), .phase(phase), .wait_ilv(wait_ilv), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    // One write beat; returns at the falling edge after its accepting edge.
    task automatic wr_beat(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R1: reset state and the unprompted first write request.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 phase in reset", 32'(phase), 32'd0);
        chk("R1 err in reset", 32'(err), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 boot wr_req_evt", 32'(wr_req_evt), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 boot pulse ends", 32'(wr_req_evt), 32'd0);
    endtask

    // R2 to R8: one complete frame, optionally with a write while busy.
    task automatic t_frame(input int fl, input bit busy_write);
        int dat_n = 2 * ((fl + 1) / 2);
        int ilv_n = 2 * ((fl + 6) / 4);
        int res_n = (fl + 31) / 32;
        int k;
        chk("R7 phase before frame", 32'(phase), 32'd0);
        for (int i = 0; i < 16; i++) begin
            wr_beat(i == 0 ? {16'hA5A5, 4'h0, 12'(fl)} : 32'h1111_0000 + 32'(i));
            if (i < 15) chk("R2 no early wr_req", 32'(wr_req_evt), 32'd0);
        end
        chk("R2 cfg done wr_req", 32'(wr_req_evt), 32'd1);
        chk("R2 phase data", 32'(phase), 32'd1);
        for (int i = 0; i < dat_n; i++) begin
            wr_beat(32'h2222_0000 + 32'(i));
            if (i < dat_n - 1) chk("R3 no early wr_req", 32'(wr_req_evt), 32'd0);
        end
        chk("R3 data done wr_req", 32'(wr_req_evt), 32'd1);
        chk("R3 phase ilv", 32'(phase), 32'd2);
        for (int i = 0; i < ilv_n; i++) begin
            if (i == ilv_n - 1) begin
                chk("R4 wait_ilv before last", 32'(wait_ilv), 32'd1);
                chk("R4 phase before last", 32'(phase), 32'd2);
            end
            wr_beat(32'h3333_0000 + 32'(i));
            if (i < ilv_n - 1) chk("R4 no rd_req", 32'(rd_req_evt), 32'd0);
        end
        chk("R5 phase busy", 32'(phase), 32'd3);
        chk("R5 wait_ilv cleared", 32'(wait_ilv), 32'd0);
        k = 0;
        if (busy_write) begin
            wr_beat(32'hDEAD_BEEF);
            k = 1;
            chk("R8 err set", 32'(err), 32'd1);
            chk("R8 phase unchanged", 32'(phase), 32'd3);
        end
        while (!rd_req_evt && k < 50) begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        chk("R5 rd_req latency", 32'(k), 32'(PROC));
        chk("R9 no wr_req while busy", 32'(wr_req_evt), 32'd0);
        for (int i = 0; i < res_n; i++) begin
            chk("R6 result word", rd_data, {16'(i), 16'(fl)});
            rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd_en = 1'b0;
            if (i == 0) chk("R9 rd_req pulse ends", 32'(rd_req_evt), 32'd0);
            if (i < res_n - 1) chk("R7 no early wr_req", 32'(wr_req_evt), 32'd0);
        end
        chk("R7 next frame wr_req", 32'(wr_req_evt), 32'd1);
        chk("R7 phase back to cfg", 32'(phase), 32'd0);
        chk("R6 rd_data idle", rd_data, 32'd0);
        if (busy_write) chk("R8 err still set", 32'(err), 32'd1);
    endtask

    initial begin
        t_reset();
        t_frame(1, 1'b0);
        t_frame(5, 1'b0);
        t_frame(40, 1'b1);
        t_frame(70, 1'b0);
        t_reset();
        chk("R8 err cleared by reset", 32'(err), 32'd0);
        t_frame(3, 1'b0);
        finish_run();
    end
endmodule